// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two thresholds used by a synchronous FIFO's programmable flags: one offset for almost-empty and one for almost-full. Both are set and checked through the FIFO's own 9-bit data ports, so no separate register port is needed. A shared select line, `cfg_sel`, switches the ports from FIFO traffic to offset access.

While `cfg_sel` is high, each write-clock edge with `wr_en` high stores the input word into the next of four offset halves. Each read-clock edge with both read enables high places the next half on `rd_data`. The four halves follow one fixed circular order, and the write side and the read side each keep their own position in it. An offset wider than the data port is split: the low half holds data bits 0 to 8 and the high half holds the remaining upper bits.

The block supplies both offsets to the flag comparators, together with the almost-full threshold level. It also gates the FIFO push and pop strobes, so traffic in offset mode leaves the storage pointers untouched. The offset width is log2 of the FIFO depth and must exceed the data width.

Top module: `flag_ofs_ctrl`

## Requirements
- R1: After reset, both offsets equal 7, `af_level` equals DEPTH-7, `rd_data` is 0, and the write and read sequence positions both point at the first half.
- R2: A write-clock edge with `cfg_sel`=1 and `wr_en`=1 stores `wr_data` into the current half. The order of halves is 0 almost-empty low, 1 almost-empty high, 2 almost-full low, 3 almost-full high. The new value shows on `ae_off`/`af_off` after that edge.
- R3: A write-clock edge without both `cfg_sel`=1 and `wr_en`=1 changes no offset and leaves the write position where it is.
- R4: Each sequence position advances by one half on each qualified transfer and wraps from half 3 back to half 0.
- R5: A read-clock edge with `cfg_sel`=1, `rd_en_a`=1 and `rd_en_b`=1 loads `rd_data` with the current half, in the same order as R2, and then advances the read position.
- R6: A read-clock edge without `cfg_sel` and both read enables high leaves `rd_data` and the read position unchanged.
- R7: A high half stores only `wr_data[OFS_W-10:0]`, which is bits 4:0 at the default depth. On readback the bits above that field are 0.
- R8: The write and read positions are independent: transfers on one side never move the other side's position.
- R9: `af_level` always equals DEPTH minus `af_off`.
- R10: `fifo_push` is `wr_en` and `fifo_pop` is `rd_en_a & rd_en_b`, each forced to 0 while `cfg_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| cfg_sel | input | 1 | High selects offset access instead of FIFO access |
| wr_en | input | 1 | Write enable |
| wr_data | input | 9 | Write data / offset half |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_data | output | 9 | Offset half read back |
| ae_off | output | OFS_W (14) | Almost-empty offset |
| af_off | output | OFS_W (14) | Almost-full offset |
| af_level | output | OFS_W+1 (15) | Fill level at which almost-full asserts |
| fifo_push | output | 1 | Gated write strobe to FIFO storage |
| fifo_pop | output | 1 | Gated read strobe to FIFO storage |

## Verification
- **Offset stores:** the result appears on `ae_off`/`af_off` one write-clock edge after the qualified write. The bench drives inputs on a falling edge and checks on the next falling edge, half a cycle after the updating edge.
- **Readback:** it is due on `rd_data` one read-clock edge after the qualified read and is sampled on the following read-clock falling edge.
- **Level and strobes:** `af_level` and the push/pop gating are combinational. They are checked 1 ns after the inputs settle.
- **Reset release:** each domain needs two edges of its own clock after `rst_n` rises, so the bench waits four cycles before its first transfer.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    H_AE_LO = 2'd0,
    H_AE_HI = 2'd1,
    H_AF_LO = 2'd2,
    H_AF_HI = 2'd3
  } half_e;
endpackage

// File: rtl/ofs_rst_sync.sv
module ofs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ofs_seq.sv
// Circular position over the four offset halves.
module ofs_seq
  import ofs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  output half_e half
);
  logic [1:0] pos_q;
  logic [1:0] pos_d;

  always_comb begin
    pos_d = pos_q;
    if (adv) pos_d = pos_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= 2'd0;
    else        pos_q <= pos_d;
  end

  assign half = half_e'(pos_q);
endmodule

// File: rtl/ofs_store.sv
// Holds the two offsets, each split into a low and a high half.
module ofs_store
  import ofs_pkg::*;
#(
  parameter int DW        = 9,
  parameter int OFS_W     = 14,
  parameter int RESET_VAL = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  half_e            sel,
  input  logic [DW-1:0]    wr_data,
  output logic [OFS_W-1:0] ae_off,
  output logic [OFS_W-1:0] af_off
);
  localparam int HI_W = OFS_W - DW;
  localparam logic [OFS_W-1:0] RV = OFS_W'(RESET_VAL);

  logic [OFS_W-1:0] ofs [2];

  for (genvar g = 0; g < 2; g++) begin : g_ofs
    localparam half_e LO_SEL = half_e'(2 * g);
    localparam half_e HI_SEL = half_e'(2 * g + 1);

    logic [DW-1:0]   lo_q, lo_d;
    logic [HI_W-1:0] hi_q, hi_d;
    logic            lo_en, hi_en;

    always_comb begin
      lo_en = we && (sel == LO_SEL);
      hi_en = we && (sel == HI_SEL);
      lo_d  = lo_q;
      hi_d  = hi_q;
      if (lo_en) lo_d = wr_data;
      if (hi_en) hi_d = wr_data[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= RV[DW-1:0];
        hi_q <= RV[OFS_W-1:DW];
      end else begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
    end

    assign ofs[g] = {hi_q, lo_q};
  end

  assign ae_off = ofs[0];
  assign af_off = ofs[1];
endmodule

// File: rtl/flag_ofs_ctrl.sv
module flag_ofs_ctrl
  import ofs_pkg::*;
#(
  parameter int DEPTH     = 16384,
  parameter int DW        = 9,
  parameter int RESET_VAL = 7
) (
  input  logic                   wr_clk,
  input  logic                   rd_clk,
  input  logic                   rst_n,
  input  logic                   cfg_sel,
  input  logic                   wr_en,
  input  logic [DW-1:0]          wr_data,
  input  logic                   rd_en_a,
  input  logic                   rd_en_b,
  output logic [DW-1:0]          rd_data,
  output logic [$clog2(DEPTH)-1:0] ae_off,
  output logic [$clog2(DEPTH)-1:0] af_off,
  output logic [$clog2(DEPTH):0]   af_level,
  output logic                   fifo_push,
  output logic                   fifo_pop
);
  localparam int OFS_W = $clog2(DEPTH);
  localparam int HI_W  = OFS_W - DW;

  logic       wr_rst_n, rd_rst_n;
  logic       wr_go, rd_go;
  half_e      wr_half, rd_half;
  logic [1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] rd_sel;
  logic [DW-1:0] rd_q, rd_d;

  ofs_rst_sync #(.STAGES(2)) u_wr_rst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_n));
  ofs_rst_sync #(.STAGES(2)) u_rd_rst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_n));

  assign wr_go     = cfg_sel & wr_en;
  assign rd_go     = cfg_sel & rd_en_a & rd_en_b;
  assign fifo_push = wr_en & ~cfg_sel;
  assign fifo_pop  = rd_en_a & rd_en_b & ~cfg_sel;

  ofs_seq u_wr_seq (.clk(wr_clk), .rst_n(wr_rst_n), .adv(wr_go), .half(wr_half));
  ofs_seq u_rd_seq (.clk(rd_clk), .rst_n(rd_rst_n), .adv(rd_go), .half(rd_half));

  assign wr_ptr = wr_half;
  assign rd_ptr = rd_half;

  ofs_store #(.DW(DW), .OFS_W(OFS_W), .RESET_VAL(RESET_VAL)) u_store (
    .clk     (wr_clk),
    .rst_n   (wr_rst_n),
    .we      (wr_go),
    .sel     (wr_half),
    .wr_data (wr_data),
    .ae_off  (ae_off),
    .af_off  (af_off)
  );

  // Readback: offsets change only under software control, sampled here quasi-statically.
  always_comb begin
    unique case (rd_half)
      H_AE_LO: rd_sel = ae_off[DW-1:0];
      H_AE_HI: rd_sel = DW'(ae_off[OFS_W-1:DW]);
      H_AF_LO: rd_sel = af_off[DW-1:0];
      default: rd_sel = DW'(af_off[OFS_W-1:DW]);
    endcase
    rd_d = rd_q;
    if (rd_go) rd_d = rd_sel;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rd_q <= '0;
    else           rd_q <= rd_d;
  end

  assign rd_data  = rd_q;
  assign af_level = (OFS_W + 1)'(DEPTH) - {1'b0, af_off};
endmodule

// File: rtl/ofs_chk.sv
module ofs_chk #(
  parameter int DW    = 9,
  parameter int OFS_W = 14
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             wr_rst_n,
  input logic             rd_rst_n,
  input logic             cfg_sel,
  input logic             wr_en,
  input logic             rd_en_a,
  input logic             rd_en_b,
  input logic [DW-1:0]    rd_data,
  input logic [OFS_W-1:0] ae_off,
  input logic [OFS_W-1:0] af_off,
  input logic [1:0]       wr_ptr,
  input logic [1:0]       rd_ptr
);
  localparam int HI_W = OFS_W - DW;

  // R3
  idle_wr_stable_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !(cfg_sel && wr_en) |=> ($stable(ae_off) && $stable(af_off) && $stable(wr_ptr)));

  // R2
  one_offset_per_write_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (cfg_sel && wr_en) |=> ($stable(ae_off) || $stable(af_off)));

  // R4
  wr_ptr_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (cfg_sel && wr_en) |=> (wr_ptr == $past(wr_ptr) + 2'd1));

  // R4
  rd_ptr_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (cfg_sel && rd_en_a && rd_en_b) |=> (rd_ptr == $past(rd_ptr) + 2'd1));

  // R6
  idle_rd_stable_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(cfg_sel && rd_en_a && rd_en_b) |=> ($stable(rd_data) && $stable(rd_ptr)));

  // R7
  hi_zero_ext_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (cfg_sel && rd_en_a && rd_en_b && rd_ptr[0]) |=> (rd_data[DW-1:HI_W] == '0));
endmodule

bind flag_ofs_ctrl ofs_chk #(.DW(DW), .OFS_W(OFS_W)) u_ofs_chk (
  .wr_clk   (wr_clk),
  .rd_clk   (rd_clk),
  .wr_rst_n (wr_rst_n),
  .rd_rst_n (rd_rst_n),
  .cfg_sel  (cfg_sel),
  .wr_en    (wr_en),
  .rd_en_a  (rd_en_a),
  .rd_en_b  (rd_en_b),
  .rd_data  (rd_data),
  .ae_off   (ae_off),
  .af_off   (af_off),
  .wr_ptr   (wr_ptr),
  .rd_ptr   (rd_ptr)
);

// File: tb/flag_ofs_ctrl_bench.sv
module flag_ofs_ctrl_bench;
  localparam int DEPTH = 16384;
  localparam int DW    = 9;
  localparam int OFS_W = $clog2(DEPTH);
  localparam int HI_W  = OFS_W - DW;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rst_n, cfg_sel, wr_en, rd_en_a, rd_en_b;
  logic [DW-1:0] wr_data, rd_data;
  logic [OFS_W-1:0] ae_off, af_off;
  logic [OFS_W:0] af_level;
  logic fifo_push, fifo_pop;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [DW-1:0]   m_lo [2];
  logic [HI_W-1:0] m_hi [2];
  int wp, rp;

  always #2 wr_clk = ~wr_clk;
  initial begin
    #1;
    forever #2 rd_clk = ~rd_clk;
  end

  flag_ofs_ctrl #(.DEPTH(DEPTH), .DW(DW), .RESET_VAL(7)) u_flag_ofs_ctrl (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_sel(cfg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
    .rd_data(rd_data), .ae_off(ae_off), .af_off(af_off), .af_level(af_level),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [OFS_W-1:0] m_ofs(input int k);
    return {m_hi[k], m_lo[k]};
  endfunction

  function automatic logic [DW-1:0] m_half(input int h);
    if (h % 2 == 0) return m_lo[h / 2];
    return DW'(m_hi[h / 2]);
  endfunction

  task automatic check_offsets(input string req);
    chk(req, "ae_off", 32'(ae_off), 32'(m_ofs(0)));
    chk(req, "af_off", 32'(af_off), 32'(m_ofs(1)));
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    @(negedge wr_clk);
    cfg_sel = 1'b1; wr_en = 1'b1; wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
    case (wp)
      0: m_lo[0] = d;
      1: m_hi[0] = d[HI_W-1:0];
      2: m_lo[1] = d;
      default: m_hi[1] = d[HI_W-1:0];
    endcase
    wp = (wp + 1) % 4;
  endtask

  task automatic do_read(input string req);
    logic [DW-1:0] exp_v;
    exp_v = m_half(rp);
    @(negedge rd_clk);
    cfg_sel = 1'b1; rd_en_a = 1'b1; rd_en_b = 1'b1;
    @(negedge rd_clk);
    rd_en_a = 1'b0; rd_en_b = 1'b0;
    chk(req, "rd_data", 32'(rd_data), 32'(exp_v));
    rp = (rp + 1) % 4;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cfg_sel = 1'b0; wr_en = 1'b0; rd_en_a = 1'b0; rd_en_b = 1'b0; wr_data = '0;
    m_lo[0] = 9'd7; m_lo[1] = 9'd7; m_hi[0] = '0; m_hi[1] = '0; wp = 0; rp = 0;
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    chk("R1", "ae_off", 32'(ae_off), 32'd7);
    chk("R1", "af_off", 32'(af_off), 32'd7);
    chk("R1", "af_level", 32'(af_level), 32'(DEPTH - 7));
    chk("R1", "rd_data", 32'(rd_data), 32'd0);
    for (int i = 0; i < 4; i++) do_read("R1");
  endtask

  task automatic t_load;
    logic [DW-1:0] vals [4];
    vals = '{9'h1A5, 9'h013, 9'h0F0, 9'h002};
    for (int i = 0; i < 4; i++) begin
      do_write(vals[i]);
      check_offsets("R2");
    end
    #1 chk("R9", "af_level", 32'(af_level), 32'(DEPTH) - 32'(m_ofs(1)));
    for (int i = 0; i < 4; i++) do_read("R5");
  endtask

  task automatic t_wrap_hi;
    do_write(9'h055);
    chk("R4", "ae_off low after wrap", 32'(ae_off[DW-1:0]), 32'h055);
    do_write(9'h1FF);
    chk("R7", "ae_off high truncated", 32'(ae_off), {18'd0, 5'h1F, 9'h055});
    do_write(9'h100);
    do_write(9'h1E0);
    check_offsets("R7");
    #1 chk("R9", "af_level", 32'(af_level), 32'(DEPTH) - 32'(m_ofs(1)));
    for (int i = 0; i < 4; i++) do_read("R7");
  endtask

  task automatic t_ignore;
    logic [DW-1:0] held;
    @(negedge wr_clk);
    cfg_sel = 1'b0; wr_en = 1'b1; wr_data = 9'h003;
    repeat (2) @(negedge wr_clk);
    cfg_sel = 1'b1; wr_en = 1'b0;
    repeat (2) @(negedge wr_clk);
    check_offsets("R3");
    held = rd_data;
    @(negedge rd_clk);
    rd_en_a = 1'b1; rd_en_b = 1'b0;
    repeat (2) @(negedge rd_clk);
    rd_en_a = 1'b0; rd_en_b = 1'b1;
    repeat (2) @(negedge rd_clk);
    cfg_sel = 1'b0; rd_en_a = 1'b1;
    repeat (2) @(negedge rd_clk);
    rd_en_a = 1'b0; rd_en_b = 1'b0;
    @(negedge rd_clk);
    chk("R6", "rd_data held", 32'(rd_data), 32'(held));
    do_write(9'h0AA);
    chk("R3", "write lands on first half", 32'(ae_off[DW-1:0]), 32'h0AA);
    do_read("R6");
  endtask

  task automatic t_indep;
    do_write(9'h011);
    do_write(9'h1C3);
    do_read("R8");
    check_offsets("R8");
    do_write(9'h004);
    do_read("R8");
    do_read("R8");
    check_offsets("R8");
  endtask

  task automatic t_gate;
    @(negedge wr_clk);
    cfg_sel = 1'b0; wr_en = 1'b1; rd_en_a = 1'b1; rd_en_b = 1'b1;
    #1;
    chk("R10", "fifo_push open", 32'(fifo_push), 32'd1);
    chk("R10", "fifo_pop open", 32'(fifo_pop), 32'd1);
    rd_en_b = 1'b0;
    #1 chk("R10", "fifo_pop needs both", 32'(fifo_pop), 32'd0);
    wr_en = 1'b0; rd_en_a = 1'b0;
    @(negedge wr_clk);
    #0.5;
    cfg_sel = 1'b1; wr_en = 1'b1; rd_en_a = 1'b1; rd_en_b = 1'b1;
    #0.4;
    chk("R10", "fifo_push gated", 32'(fifo_push), 32'd0);
    chk("R10", "fifo_pop gated", 32'(fifo_pop), 32'd0);
    wr_en = 1'b0; rd_en_a = 1'b0; rd_en_b = 1'b0;
  endtask

  initial begin
    t_reset();
    t_load();
    t_wrap_hi();
    t_ignore();
    t_indep();
    t_gate();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule